// File: doc/BRIEF.md
# PCI Parity Error Monitor

This block sits beside a PCI target on a 32-bit bus and checks every parity-protected phase it can see. Each clock it keeps a copy of AD and C/BE#. On the next clock PAR arrives, and the block compares PAR with the even parity of the copy. A bad address phase is reported on any transaction on the bus, whether or not this device is addressed. A bad data phase is reported only when this device is the selected target. The block never ends or stalls a transaction. Even after a bad address phase, the target logic around it keeps claiming the cycle and runs it as if the address were valid.

Reporting is set by two command-register enables: parity response, and system-error enable. A bad data phase drives PERR# for one clock when parity response is set. A bad address phase pulses SERR# when both enables are set. Any detected error sets the sticky "parity error detected" status bit, whatever the enables are. An SERR# pulse also sets the sticky "system error signalled" bit. Software clears each status bit by writing a one to its clear input.

Top module: `pci_parity_monitor`

## Requirements
- R1: Parity is even over AD[31:0] and C/BE#[3:0] together with PAR. PAR is sampled one clock after the phase it covers. A phase is in error when the XOR of the 37 bits is 1.
- R2: A data phase is a clock with IRDY# and TRDY# both low while `target_sel_i` is high. If such a phase is bad and `perr_resp_en_i` is high in the clock when PAR is sampled, `perr_n_o` is low in the second clock after the data phase. It stays low for exactly one clock per bad data phase, so back-to-back bad phases give back-to-back low clocks.
- R3: A bad data phase with `perr_resp_en_i` low leaves `perr_n_o` high but still sets `stat_dpe_o`.
- R4: An address phase is a clock with FRAME# low after a clock with FRAME# high. Its parity is checked whatever the value of `target_sel_i`.
- R5: A bad address phase with both `perr_resp_en_i` and `serr_en_i` high in the PAR clock drives `serr_n_o` low for exactly one clock, two clocks after the address phase. It also sets both `stat_sse_o` and `stat_dpe_o`.
- R6: A bad address phase with either enable low leaves `serr_n_o` high and sets only `stat_dpe_o`.
- R7: Both status bits hold their value until a one on the matching clear input (`clr_dpe_i`, `clr_sse_i`) clears them one clock later. A set and a clear in the same clock leave the bit set.
- R8: Synchronous active-high reset drives `perr_n_o` and `serr_n_o` high and both status bits to 0.
- R9: Clocks that are neither an address phase nor a data phase of this target report nothing, whatever PAR is. This includes wait states, idle clocks and data phases of other targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI bus clock |
| rst | input | 1 | Synchronous reset, active high |
| ad_i | input | 32 | Multiplexed address/data bus |
| cbe_n_i | input | 4 | Command / byte enables, active low |
| par_i | input | 1 | Even parity for the previous clock's AD and C/BE# |
| frame_n_i | input | 1 | FRAME#, active low |
| irdy_n_i | input | 1 | IRDY#, active low |
| trdy_n_i | input | 1 | TRDY#, active low |
| target_sel_i | input | 1 | This device is the selected target of the current transaction |
| perr_resp_en_i | input | 1 | Command register parity-response enable |
| serr_en_i | input | 1 | Command register system-error enable |
| clr_dpe_i | input | 1 | Write-one-to-clear for the detected-parity status bit |
| clr_sse_i | input | 1 | Write-one-to-clear for the signalled-system-error status bit |
| perr_n_o | output | 1 | Data parity error, active low, registered |
| serr_n_o | output | 1 | System error, active low, registered |
| stat_dpe_o | output | 1 | Sticky parity-error-detected status (status bit 15) |
| stat_sse_o | output | 1 | Sticky system-error-signalled status (status bit 14) |

## Verification
On every cycle the assertions check four things. SERR# never stays low for two clocks, and it is low only after both enables were set. PERR# is low only after parity response was enabled. Any PERR# or SERR# report comes with the detected-parity status bit. The status bits fall only after a clear request, and two address phases never occur back to back.

Some behaviours only the bench scenarios can show, because the bench model recomputes parity from the driven bus. These are the exact two-clock latency, reports of address errors on transactions aimed at other targets, silence on wait states and on other targets' data phases, and every enable combination.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
  // Phase classification of one captured bus clock
  typedef struct packed {
    logic addr_ph;   // first clock of FRAME# low
    logic data_ph;   // IRDY#/TRDY# handshake while selected
  } phase_t;

  localparam int unsigned DEF_AD_W = 32;
endpackage

// File: rtl/ppm_parity.sv
module ppm_parity #(
  parameter int unsigned W = 36
) (
  input  logic [W-1:0] data_i,
  output logic         odd_o
);
  logic [W:0] chain;
  assign chain[0] = 1'b0;
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_xor
      assign chain[gi+1] = chain[gi] ^ data_i[gi];
    end
  endgenerate
  assign odd_o = chain[W];
endmodule

// File: rtl/ppm_phase_capture.sv
module ppm_phase_capture
  import ppm_pkg::*;
#(
  parameter int unsigned AD_W = DEF_AD_W,
  parameter int unsigned BE_W = AD_W / 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_n_i,
  input  logic            frame_n_i,
  input  logic            irdy_n_i,
  input  logic            trdy_n_i,
  input  logic            target_sel_i,
  output logic [AD_W-1:0] ad_q,
  output logic [BE_W-1:0] cbe_q,
  output phase_t          phase_q
);
  logic frame_n_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_n_prev <= 1'b1;
      ad_q         <= '0;
      cbe_q        <= '0;
      phase_q      <= '0;
    end else begin
      frame_n_prev    <= frame_n_i;
      ad_q            <= ad_i;
      cbe_q           <= cbe_n_i;
      phase_q.addr_ph <= frame_n_prev && !frame_n_i;
      phase_q.data_ph <= !irdy_n_i && !trdy_n_i && target_sel_i;
    end
  end

  // R4: an address phase needs FRAME# high the clock before, so never two in a row
  assert_no_double_addr_R4: assert property (@(posedge clk) disable iff (rst)
    phase_q.addr_ph |=> !phase_q.addr_ph);
endmodule

// File: rtl/ppm_error_report.sv
module ppm_error_report
  import ppm_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t phase_i,
  input  logic   calc_odd_i,
  input  logic   par_i,
  input  logic   perr_resp_en_i,
  input  logic   serr_en_i,
  input  logic   clr_dpe_i,
  input  logic   clr_sse_i,
  output logic   perr_n_o,
  output logic   serr_n_o,
  output logic   stat_dpe_o,
  output logic   stat_sse_o
);
  logic mismatch, addr_bad, data_bad, raise_serr;

  always_comb begin
    mismatch   = calc_odd_i ^ par_i;
    addr_bad   = phase_i.addr_ph && mismatch;
    data_bad   = phase_i.data_ph && mismatch;
    raise_serr = addr_bad && perr_resp_en_i && serr_en_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      perr_n_o   <= 1'b1;
      serr_n_o   <= 1'b1;
      stat_dpe_o <= 1'b0;
      stat_sse_o <= 1'b0;
    end else begin
      perr_n_o <= !(data_bad && perr_resp_en_i);
      serr_n_o <= !raise_serr;
      if (addr_bad || data_bad) stat_dpe_o <= 1'b1;
      else if (clr_dpe_i)       stat_dpe_o <= 1'b0;
      if (raise_serr)           stat_sse_o <= 1'b1;
      else if (clr_sse_i)       stat_sse_o <= 1'b0;
    end
  end

  assert_serr_one_clock_R5: assert property (@(posedge clk) disable iff (rst)
    !serr_n_o |=> serr_n_o);
  assert_serr_gated_R6: assert property (@(posedge clk) disable iff (rst)
    !serr_n_o |-> ($past(perr_resp_en_i) && $past(serr_en_i)));
  assert_perr_gated_R3: assert property (@(posedge clk) disable iff (rst)
    !perr_n_o |-> $past(perr_resp_en_i));
  assert_report_sets_dpe_R1: assert property (@(posedge clk) disable iff (rst)
    (!perr_n_o || !serr_n_o) |-> stat_dpe_o);
  assert_dpe_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(stat_dpe_o) && !$past(rst)) |-> $past(clr_dpe_i));
  assert_sse_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(stat_sse_o) && !$past(rst)) |-> $past(clr_sse_i));
endmodule

// File: rtl/pci_parity_monitor.sv
module pci_parity_monitor
  import ppm_pkg::*;
#(
  parameter int unsigned AD_W = DEF_AD_W,
  parameter int unsigned BE_W = AD_W / 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_n_i,
  input  logic            par_i,
  input  logic            frame_n_i,
  input  logic            irdy_n_i,
  input  logic            trdy_n_i,
  input  logic            target_sel_i,
  input  logic            perr_resp_en_i,
  input  logic            serr_en_i,
  input  logic            clr_dpe_i,
  input  logic            clr_sse_i,
  output logic            perr_n_o,
  output logic            serr_n_o,
  output logic            stat_dpe_o,
  output logic            stat_sse_o
);
  localparam int unsigned CHK_W = AD_W + BE_W;

  logic [AD_W-1:0] ad_q;
  logic [BE_W-1:0] cbe_q;
  phase_t          phase_q;
  logic            calc_odd;

  ppm_phase_capture #(.AD_W(AD_W), .BE_W(BE_W)) u_capture (
    .clk(clk), .rst(rst), .ad_i(ad_i), .cbe_n_i(cbe_n_i),
    .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i), .trdy_n_i(trdy_n_i),
    .target_sel_i(target_sel_i), .ad_q(ad_q), .cbe_q(cbe_q), .phase_q(phase_q)
  );

  ppm_parity #(.W(CHK_W)) u_parity (
    .data_i({cbe_q, ad_q}), .odd_o(calc_odd)
  );

  ppm_error_report u_report (
    .clk(clk), .rst(rst), .phase_i(phase_q), .calc_odd_i(calc_odd),
    .par_i(par_i), .perr_resp_en_i(perr_resp_en_i), .serr_en_i(serr_en_i),
    .clr_dpe_i(clr_dpe_i), .clr_sse_i(clr_sse_i),
    .perr_n_o(perr_n_o), .serr_n_o(serr_n_o),
    .stat_dpe_o(stat_dpe_o), .stat_sse_o(stat_sse_o)
  );
endmodule

// File: tb/pci_parity_monitor_bench.sv
module pci_parity_monitor_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic par = 1'b0, frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, sel = 1'b0;
  logic pre = 1'b0, sen = 1'b0, clr_dpe = 1'b0, clr_sse = 1'b0;
  logic perr_n, serr_n, dpe, sse;

  always #10 clk = ~clk;   // 50 MHz

  pci_parity_monitor u_pci_parity_monitor (
    .clk(clk), .rst(rst), .ad_i(ad), .cbe_n_i(cbe), .par_i(par),
    .frame_n_i(frame_n), .irdy_n_i(irdy_n), .trdy_n_i(trdy_n),
    .target_sel_i(sel), .perr_resp_en_i(pre), .serr_en_i(sen),
    .clr_dpe_i(clr_dpe), .clr_sse_i(clr_sse),
    .perr_n_o(perr_n), .serr_n_o(serr_n), .stat_dpe_o(dpe), .stat_sse_o(sse)
  );

  int checks = 0, errors = 0;
  bit started = 0;

  // Reference model: remembers the previous clock's phase, judges it with PAR now.
  logic e_perr = 1, e_serr = 1, e_dpe = 0, e_sse = 0;
  logic prev_frame = 1, pend_addr = 0, pend_data = 0, pend_odd = 0;
  always @(posedge clk) begin
    if (rst) begin
      e_perr = 1; e_serr = 1; e_dpe = 0; e_sse = 0;
      prev_frame = 1; pend_addr = 0; pend_data = 0;
    end else begin
      bit bad;
      bad = (pend_odd != par);
      e_perr = !(pend_data && bad && pre);
      e_serr = !(pend_addr && bad && pre && sen);
      if ((pend_addr || pend_data) && bad) e_dpe = 1; else if (clr_dpe) e_dpe = 0;
      if (!e_serr) e_sse = 1; else if (clr_sse) e_sse = 0;
      pend_odd  = ($countones({cbe, ad}) % 2) == 1;
      pend_addr = prev_frame && !frame_n;
      pend_data = !irdy_n && !trdy_n && sel;
      prev_frame = frame_n;
    end
    started = 1;
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started && !rst) begin
    chk("R2", "perr_n", perr_n, e_perr);
    chk("R5", "serr_n", serr_n, e_serr);
    chk("R1", "stat_dpe", dpe, e_dpe);
    chk("R5", "stat_sse", sse, e_sse);
  end

  logic par_next = 1'b0;
  logic clr_dpe_req = 0, clr_sse_req = 0;
  task automatic step(input logic [31:0] a, input logic [3:0] be, input logic fr,
                      input logic ir, input logic tr, input logic s, input logic inj);
    @(negedge clk);
    ad = a; cbe = be; frame_n = fr; irdy_n = ir; trdy_n = tr; sel = s;
    par = par_next;
    par_next = (^{be, a}) ^ inj;
    clr_dpe = clr_dpe_req; clr_sse = clr_sse_req;
    clr_dpe_req = 0; clr_sse_req = 0;
  endtask

  task automatic idle(input int n, input logic inj);
    for (int i = 0; i < n; i++) step(32'hA5A5_0000 + i, 4'hF, 1, 1, 1, 0, inj);
  endtask

  // Address phase then n data phases; mask bit i corrupts data phase i.
  task automatic xact(input logic s, input logic abad, input int n, input logic [7:0] mask);
    step(32'h1000_0040, 4'h6, 0, 1, 1, s, abad);
    for (int i = 0; i < n; i++)
      step(32'hC0DE_0000 ^ (i * 32'h0101_0307), 4'h0, (i == n - 1), 0, 0, s, mask[i]);
    idle(3, 1'b0);
  endtask

  task automatic clear_all();
    clr_dpe_req = 1; clr_sse_req = 1;
    idle(2, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", "reset perr_n", perr_n, 1'b1);
    chk("R8", "reset serr_n", serr_n, 1'b1);
    chk("R8", "reset dpe", dpe, 1'b0);
    chk("R8", "reset sse", sse, 1'b0);
    rst = 0;
    idle(2, 1'b1);                                  // R9: garbage PAR on idle clocks
    chk("R9", "idle dpe", dpe, 1'b0);

    pre = 1; sen = 1;
    xact(1, 0, 4, 8'h00);
    chk("R9", "clean dpe", dpe, 1'b0);
    xact(1, 0, 4, 8'h02);
    chk("R2", "data err dpe", dpe, 1'b1);
    chk("R2", "data err sse", sse, 1'b0);
    clear_all();
    chk("R7", "cleared dpe", dpe, 1'b0);
    xact(1, 0, 3, 8'h03);                           // R2 back-to-back PERR#
    clear_all();

    pre = 0;
    xact(1, 0, 2, 8'h01);
    chk("R3", "silent data err dpe", dpe, 1'b1);
    clear_all();
    pre = 1;
    xact(0, 0, 3, 8'h07);                           // not our data phases
    chk("R9", "foreign data dpe", dpe, 1'b0);

    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 2; s++) begin
        pre = c[0]; sen = c[1];
        xact(s[0], 1, 2, 8'h00);
        chk("R4", "addr err dpe", dpe, 1'b1);
        chk((c == 3) ? "R5" : "R6", "addr err sse", sse, (c == 3));
        idle(2, 1'b0);
        chk("R7", "sticky dpe", dpe, 1'b1);
        clear_all();
      end
    end

    // wait state with corrupted PAR: IRDY# high, TRDY# low
    pre = 1; sen = 1;
    step(32'h2000_0000, 4'h7, 0, 1, 1, 1, 0);
    step(32'h1111_2222, 4'h0, 0, 1, 0, 1, 1);
    step(32'h3333_4444, 4'h0, 1, 0, 0, 1, 0);
    idle(3, 1'b0);
    chk("R9", "wait state dpe", dpe, 1'b0);

    // R7: clear in the same clock as the set
    step(32'h4000_0000, 4'h6, 0, 1, 1, 0, 1);
    clr_dpe_req = 1; clr_sse_req = 1;
    step(32'h0, 4'h0, 1, 0, 0, 0, 0);
    idle(2, 1'b0);
    chk("R7", "set wins dpe", dpe, 1'b1);
    chk("R7", "set wins sse", sse, 1'b1);
    clr_sse_req = 1;
    idle(2, 1'b0);
    chk("R7", "only sse cleared", sse, 1'b0);
    chk("R7", "dpe kept", dpe, 1'b1);
    clear_all();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R8 actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule